// File: doc/BRIEF.md
# GPIO Interrupt Unit

This block is a general-purpose I/O unit on a 16-bit register bus. It serves 32 bidirectional pins and 18 output-only pins. Each bidirectional pin has its own direction bit. As an input, a pin can raise an interrupt that is edge or level triggered. The pin's polarity bit sets which level, or which edge, is active. A separate bit per pin decides whether a detected event is held until software clears it or passes straight through.

Each input passes through a two-flop synchroniser before it reaches the edge logic. Per-pin events collect in a status register, and an enable register masks that status. The unit drives one combined, level-sensitive interrupt line to an upstream controller. Software reaches every 32-bit register as two 16-bit words. To acknowledge interrupts, software writes back the status value it has just read.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is held, every register reads back 0, all 32 bidirectional pins are inputs (`pin_oe` = 0), all outputs are 0 and `irq_out` is 0.
- R2: Each 32-bit register occupies two word addresses: bits 15:0 at the even address and bits 31:16 at the odd address. A write to one half leaves the other half unchanged. The register index is `bus_addr[3:1]`: 0 pin data, 1 output-only data, 2 direction, 3 status, 4 enable, 5 trigger type, 6 polarity, 7 hold select.
- R3: A direction bit of 1 makes the pin an output: `pin_oe` is 1 and `pin_out` carries the written pin-data bit, which reads back as written. A direction bit of 0 makes the pin an input, and its pin-data bit reads the synchronised pin level.
- R4: `opin_out[17:0]` carries bits 17:0 of the output-only data register. Bits 31:18 of that register read back as 0.
- R5: A pin level change reaches the pin data readback after exactly two rising clock edges.
- R6: With a trigger-type bit of 1 (edge), a polarity bit of 1 detects a rising edge and a polarity bit of 0 detects a falling edge. The status bit is 1 in the third cycle after the pin changes.
- R7: With a trigger-type bit of 0 (level), the pin is active while its synchronised level equals its polarity bit (1 active-high, 0 active-low).
- R8: With a hold bit of 1, a status bit stays at 1 until it is cleared. With a hold bit of 0, the status bit follows the trigger condition one cycle later, and writes to the status register do not affect it.
- R9: Status is write-1-to-clear: a 1 clears a held bit and a 0 leaves it unchanged. A held bit whose condition is still present in the clearing cycle stays at 1.
- R10: `irq_out` is 1 exactly when some pin has both its status bit and its enable bit at 1. Enable bits are 0 after reset.
- R11: A pin whose direction bit is 1 never sets its status bit, whatever its input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | 4 | Word address (register index and half) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Levels of the bidirectional pins, asynchronous |
| pin_out | output | 32 | Output values of the bidirectional pins |
| pin_oe | output | 32 | Output enables of the bidirectional pins |
| opin_out | output | 18 | Values of the output-only pins |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions expect reset to be low from time zero, because they compare status against the previous cycle and would otherwise see undefined history. They allow `pin_in` to be fully asynchronous, since every property looks only at synchronised levels. They also allow a status write and a new trigger to land in the same cycle. The stimulus changes pins and bus signals only on the falling clock edge. It holds each pin level for several cycles, so every edge and level event can be seen cleanly at the ports. A behavioural model runs alongside and is compared on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned DW       = 16;        // bus word width
    localparam int unsigned REGW     = 2 * DW;    // logical register width
    localparam int unsigned NPIN     = 32;        // bidirectional pins
    localparam int unsigned NOUT     = 18;        // output-only pins
    localparam int unsigned NREG     = 8;         // logical registers
    localparam int unsigned IDXW     = $clog2(NREG);
    localparam int unsigned AW       = IDXW + 1;  // word address width
    localparam int unsigned SYNC_LEN = 2;

    typedef enum logic [IDXW-1:0] {
        RG_PDATA = 3'd0,
        RG_ODATA = 3'd1,
        RG_DIR   = 3'd2,
        RG_STAT  = 3'd3,
        RG_EN    = 3'd4,
        RG_TYPE  = 3'd5,
        RG_POL   = 3'd6,
        RG_HOLD  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [NPIN-1:0] pdata;
        logic [NOUT-1:0] odata;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] status;
        logic [NPIN-1:0] en;
        logic [NPIN-1:0] typ;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] hold;
    } gpio_regs_t;

    function automatic logic [REGW-1:0] put_half(input logic [REGW-1:0] old,
                                                 input logic [DW-1:0]   wd,
                                                 input logic            upper);
        logic [REGW-1:0] v;
        v = old;
        if (upper) v[REGW-1:DW] = wd;
        else       v[DW-1:0]    = wd;
        return v;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W      = NPIN,
    parameter int unsigned STAGES = SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = NPIN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_sync,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pol,
    output logic [W-1:0] trig
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] rise, fall;

    always_comb prev_d = lvl_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_pin
        logic edge_hit, level_hit;
        assign rise[g]    = lvl_sync[g] & ~prev_q[g];
        assign fall[g]    = ~lvl_sync[g] & prev_q[g];
        assign edge_hit   = pol[g] ? rise[g] : fall[g];
        assign level_hit  = ~(lvl_sync[g] ^ pol[g]);
        assign trig[g]    = ~dir[g] & (typ[g] ? edge_hit : level_hit);
    end

    // R6: a synchronised rising edge can never be seen two cycles running
    p_rise_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(rise & $past(rise))));
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [NPIN-1:0] pin_sync,
    input  logic [NPIN-1:0] trig,
    output logic [DW-1:0]   bus_rdata,
    output logic [NPIN-1:0] dir_o,
    output logic [NPIN-1:0] typ_o,
    output logic [NPIN-1:0] pol_o,
    output logic [NPIN-1:0] pdata_o,
    output logic [NOUT-1:0] odata_o,
    output logic            irq_o
);
    gpio_regs_t      r_d, r_q;
    reg_idx_e        idx;
    logic            upper;
    logic            wr_hit;
    logic [NPIN-1:0] clr;
    logic [REGW-1:0] rb;

    assign idx    = reg_idx_e'(bus_addr[AW-1:1]);
    assign upper  = bus_addr[0];
    assign wr_hit = bus_sel & bus_wr;

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (wr_hit) begin
            unique case (idx)
                RG_PDATA: r_d.pdata = NPIN'(put_half(REGW'(r_q.pdata), bus_wdata, upper));
                RG_ODATA: r_d.odata = NOUT'(put_half(REGW'(r_q.odata), bus_wdata, upper));
                RG_DIR:   r_d.dir   = NPIN'(put_half(REGW'(r_q.dir),   bus_wdata, upper));
                RG_STAT:  clr       = NPIN'(put_half('0,               bus_wdata, upper));
                RG_EN:    r_d.en    = NPIN'(put_half(REGW'(r_q.en),    bus_wdata, upper));
                RG_TYPE:  r_d.typ   = NPIN'(put_half(REGW'(r_q.typ),   bus_wdata, upper));
                RG_POL:   r_d.pol   = NPIN'(put_half(REGW'(r_q.pol),   bus_wdata, upper));
                RG_HOLD:  r_d.hold  = NPIN'(put_half(REGW'(r_q.hold),  bus_wdata, upper));
                default:  ;
            endcase
        end
        // held bits: sticky with W1C, new events win; through bits: live
        r_d.status = (r_q.hold & ((r_q.status & ~clr) | trig)) | (~r_q.hold & trig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rb = '0;
        unique case (idx)
            RG_PDATA: rb = REGW'((r_q.dir & r_q.pdata) | (~r_q.dir & pin_sync));
            RG_ODATA: rb = REGW'(r_q.odata);
            RG_DIR:   rb = REGW'(r_q.dir);
            RG_STAT:  rb = REGW'(r_q.status);
            RG_EN:    rb = REGW'(r_q.en);
            RG_TYPE:  rb = REGW'(r_q.typ);
            RG_POL:   rb = REGW'(r_q.pol);
            RG_HOLD:  rb = REGW'(r_q.hold);
            default:  rb = '0;
        endcase
    end

    assign bus_rdata = upper ? rb[REGW-1:DW] : rb[DW-1:0];
    assign dir_o     = r_q.dir;
    assign typ_o     = r_q.typ;
    assign pol_o     = r_q.pol;
    assign pdata_o   = r_q.pdata;
    assign odata_o   = r_q.odata;
    assign irq_o     = |(r_q.status & r_q.en);

    // R8: a held status bit only drops after a clear was written for it
    p_held_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|($past(r_q.status & r_q.hold & ~clr) & ~r_q.status)));

    // R9: a clear of a held bit with no concurrent trigger leaves it at 0
    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|($past(clr & r_q.hold & ~trig) & r_q.status)));

    // R11: a pin that was an output cannot newly set its status bit
    p_out_pin_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|($past(r_q.dir & ~r_q.status) & r_q.status)));

    // R10: with every enable bit clear the interrupt line stays low
    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en == '0) |-> !irq_o);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic [NOUT-1:0] opin_out,
    output logic            irq_out
);
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] trig;
    logic [NPIN-1:0] dir, typ, pol;

    gpio_sync #(.W(NPIN), .STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    gpio_trig_detect #(.W(NPIN)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_sync(pin_sync),
        .dir     (dir),
        .typ     (typ),
        .pol     (pol),
        .trig    (trig)
    );

    gpio_reg_file u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pin_sync (pin_sync),
        .trig     (trig),
        .bus_rdata(bus_rdata),
        .dir_o    (dir),
        .typ_o    (typ),
        .pol_o    (pol),
        .pdata_o  (pin_out),
        .odata_o  (opin_out),
        .irq_o    (irq_out)
    );

    assign pin_oe = dir;
endmodule

// File: tb/gpio_irq_unit_tb_top.sv
module gpio_irq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic [17:0] opin_out;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .opin_out(opin_out), .irq_out(irq_out)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_pd, m_od, m_dir, m_st, m_en, m_typ, m_pol, m_hold;
    logic [31:0] m_h1, m_h2, m_h3, m_tr, m_cl;

    function automatic logic [15:0] exp_rd(input logic [3:0] a);
        logic [31:0] v;
        case (a[3:1])
            3'd0: v = (m_dir & m_pd) | (~m_dir & m_h2);
            3'd1: v = m_od & 32'h0003_FFFF;
            3'd2: v = m_dir;
            3'd3: v = m_st;
            3'd4: v = m_en;
            3'd5: v = m_typ;
            3'd6: v = m_pol;
            default: v = m_hold;
        endcase
        return a[0] ? v[31:16] : v[15:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pd = '0; m_od = '0; m_dir = '0; m_st = '0; m_en = '0;
            m_typ = '0; m_pol = '0; m_hold = '0; m_h1 = '0; m_h2 = '0; m_h3 = '0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                if (m_dir[i])      m_tr[i] = 1'b0;
                else if (m_typ[i]) m_tr[i] = m_pol[i] ? (m_h2[i] && !m_h3[i]) : (!m_h2[i] && m_h3[i]);
                else               m_tr[i] = (m_h2[i] == m_pol[i]);
            end
            m_cl = '0;
            if (bus_sel && bus_wr && bus_addr == 4'd6) m_cl[15:0]  = bus_wdata;
            if (bus_sel && bus_wr && bus_addr == 4'd7) m_cl[31:16] = bus_wdata;
            for (int i = 0; i < 32; i++) begin
                if (m_hold[i]) m_st[i] = (m_st[i] && !m_cl[i]) || m_tr[i];
                else           m_st[i] = m_tr[i];
            end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    4'd0:  m_pd[15:0]    = bus_wdata;
                    4'd1:  m_pd[31:16]   = bus_wdata;
                    4'd2:  m_od[15:0]    = bus_wdata;
                    4'd3:  m_od[31:16]   = bus_wdata;
                    4'd4:  m_dir[15:0]   = bus_wdata;
                    4'd5:  m_dir[31:16]  = bus_wdata;
                    4'd8:  m_en[15:0]    = bus_wdata;
                    4'd9:  m_en[31:16]   = bus_wdata;
                    4'd10: m_typ[15:0]   = bus_wdata;
                    4'd11: m_typ[31:16]  = bus_wdata;
                    4'd12: m_pol[15:0]   = bus_wdata;
                    4'd13: m_pol[31:16]  = bus_wdata;
                    4'd14: m_hold[15:0]  = bus_wdata;
                    4'd15: m_hold[31:16] = bus_wdata;
                    default: ;
                endcase
            end
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = pin_in;
        end
        #5;
        chk(irq_out, |(m_st & m_en), "R10 irq_out vs model");
        chk(pin_out, m_pd, "R3 pin_out vs model");
        chk(pin_oe, m_dir, "R3 pin_oe vs model");
        chk(opin_out, m_od[17:0], "R4 opin_out vs model");
        chk(bus_rdata, exp_rd(bus_addr), "R2 bus_rdata vs model");
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #5; chk(bus_rdata, e, tag);
    endtask

    task automatic setp(input logic [31:0] v);
        @(negedge clk); pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        // R1: reset state read through the bus while reset is held
        for (int a = 0; a < 16; a++) rd(4'(a), 16'h0000, "R1 reset readback");
        #1; chk(irq_out, 0, "R1 irq low in reset");
        chk(pin_oe, 0, "R1 all pins input");
        chk(opin_out, 0, "R1 output-only pins low");
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        // R10: level active-low on all low inputs sets status, but enables are 0
        rd(4'd6, 16'hFFFF, "R10 status set with enables clear");
        #1; chk(irq_out, 0, "R10 masked by enable");
        wr(4'd12, 16'hFFFF); wr(4'd13, 16'hFFFF);
        idle(3);
        rd(4'd6, 16'h0000, "R7 active-high level inactive on low pins");

        // R2/R3: upper half outputs, lower half inputs
        wr(4'd5, 16'hFFFF);
        wr(4'd1, 16'hA5A5); wr(4'd0, 16'h1234);
        setp(32'h0000_00F0);
        idle(3);
        #1; chk(pin_oe, 32'hFFFF_0000, "R2 high-half write leaves low half");
        chk(pin_out, 32'hA5A5_1234, "R3 output values");
        rd(4'd1, 16'hA5A5, "R3 output pins read back written value");
        rd(4'd0, 16'h00F0, "R3 input pins read synchronised level");
        // R5: two-edge latency
        setp(32'h0000_00F1);
        rd(4'd0, 16'h00F0, "R5 not visible after one edge");
        rd(4'd0, 16'h00F1, "R5 visible after two edges");

        // R4: output-only register
        wr(4'd2, 16'hFFFF); wr(4'd3, 16'hFFFF);
        #1; chk(opin_out, 18'h3FFFF, "R4 output-only pins");
        rd(4'd3, 16'h0003, "R4 bits 31:18 read zero");
        setp(32'h0); idle(3);

        // R6: rising edge, held, pin 0
        wr(4'd10, 16'h0001); wr(4'd14, 16'h0001); wr(4'd8, 16'h0001);
        idle(2);
        setp(32'h0000_0001);
        idle(2); #1; chk(irq_out, 0, "R6 rising edge not yet visible");
        idle(1); #1; chk(irq_out, 1, "R6 rising edge in third cycle");
        setp(32'h0); idle(4);
        #1; chk(irq_out, 1, "R8 held after pin returns low");
        wr(4'd6, 16'h0000);
        #1; chk(irq_out, 1, "R9 writing 0 has no effect");
        wr(4'd6, 16'h0001);
        #1; chk(irq_out, 0, "R9 write-1 clears held bit");

        // R6: falling edge, pin 1 with polarity 0
        wr(4'd12, 16'hFFFD); wr(4'd10, 16'h0003); wr(4'd14, 16'h0003); wr(4'd8, 16'h0002);
        setp(32'h0000_0002); idle(4);
        #1; chk(irq_out, 0, "R6 rising edge ignored when polarity 0");
        setp(32'h0);
        idle(2); #1; chk(irq_out, 0, "R6 falling edge not yet visible");
        idle(1); #1; chk(irq_out, 1, "R6 falling edge detected");
        wr(4'd6, 16'h0002);
        #1; chk(irq_out, 0, "R9 clear falling-edge event");

        // R7/R8: level active-low, through, pin 2
        wr(4'd12, 16'hFFF9); wr(4'd8, 16'h0004);
        idle(1); #1; chk(irq_out, 1, "R7 active-low level asserts");
        setp(32'h0000_0004);
        idle(2); #1; chk(irq_out, 1, "R8 through bit still live");
        idle(1); #1; chk(irq_out, 0, "R8 through bit follows condition");
        setp(32'h0); idle(3);
        #1; chk(irq_out, 1, "R7 level re-asserts");
        wr(4'd6, 16'h0004);
        #1; chk(irq_out, 1, "R8 clear ignored for through bit");
        setp(32'h0000_0004); idle(3);

        // R9: held level active-high pin 3, clear while still active
        wr(4'd14, 16'h000B); wr(4'd8, 16'h0008);
        setp(32'h0000_000C); idle(4);
        #1; chk(irq_out, 1, "R7 active-high level held");
        wr(4'd6, 16'h0008);
        #1; chk(irq_out, 1, "R9 set and clear same cycle stays set");
        rd(4'd6, 16'h0008, "R9 status after clear during active level");
        setp(32'h0000_0004); idle(4);
        #1; chk(irq_out, 1, "R8 held after level drops");
        wr(4'd6, 16'h0008);
        #1; chk(irq_out, 0, "R9 clear after level drops");

        // R11: output pin 20 cannot raise status
        wr(4'd8, 16'h0000); wr(4'd9, 16'h0010);
        setp(32'h0010_0004); idle(4);
        #1; chk(irq_out, 0, "R11 output pin ignored");
        rd(4'd7, 16'h0000, "R11 status clear for output pin");
        wr(4'd5, 16'hFFEF);
        idle(2); #1; chk(irq_out, 1, "R11 same pin raises once input");
        rd(4'd1, 16'hA5B5, "R3 switched pin reads its input level");

        idle(3);
        finish_run();
    end
endmodule